// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a hardware watchdog that requests a chip reset when software stops servicing it. It counts machine cycles, each machine cycle being a fixed number of input clocks. The count chain is twenty-one bits wide at default settings. The lowest fourteen stages are always in the path. A three-bit select value, kept in a small program register, adds between zero and seven further stages to the interval.

Software controls the watchdog through two write-only registers on a simple write strobe. One is the program register, which holds the interval select. The other is the service register. Writing the key byte 0x1E and then, as the very next write, the key byte 0xE1 to the service register starts a stopped watchdog or restarts a running one from zero. The watchdog is idle after reset and starts only when that key pair is written. If the interval runs out, the block raises a reset request for a fixed number of clocks and then returns to idle.

Counting pauses while the oscillator is halted for power-down, and also while the clock enable is low. A mode input selects between the standard machine-cycle length and a half-length machine cycle, so the watchdog can count at double speed.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the watchdog is idle. `wdt_rst` stays low for as long as no key pair is written.
- R2: A write of 0x1E to the service register (`wr_sel`=1), followed as the next write by 0xE1, starts the watchdog. With select value S, `wdt_rst` rises (2^(PRE_W+S) − 1) machine cycles after the clock edge that accepted the 0xE1 write.
- R3: Each of these leaves the watchdog idle and the count unchanged:
  - any write, to either register, between 0x1E and 0xE1;
  - a service write of any value other than 0xE1 directly after 0x1E;
  - a lone 0xE1.
  Every 0x1E write arms the sequence afresh.
- R4: A valid key pair written while the watchdog runs restarts the interval from zero.
- R5: A program-register write (`wr_sel`=0) loads the select value from `wr_data[2:0]` and ignores the upper bits. The select value resets to 0.
- R6: A machine cycle lasts SLOW_CLKS clocks when `fast_mode`=0 and FAST_CLKS clocks when `fast_mode`=1.
- R7: While `pwr_down` is high or `clk_en` is low, counting freezes. A freeze of N clocks delays the reset request by exactly N clocks.
- R8: `wdt_rst` is high for exactly PULSE_CLKS clocks per expiry. Afterwards the watchdog stays idle until a new key pair is written.
- R9: If the select value drops so that the count already meets the new interval, the watchdog expires on the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_en | input | 1 | Counting enable; low pauses the watchdog |
| pwr_down | input | 1 | High while the oscillator is halted; pauses counting |
| fast_mode | input | 1 | 1 selects the short machine cycle (double-speed counting) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 program register, 1 service register |
| wr_data | input | 8 | Write data |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
The bench builds the block with PRE_W=2, SLOW_CLKS=4, FAST_CLKS=2 and PULSE_CLKS=5, keeping the three-bit select. With these values the longest interval is 511 machine cycles. Every select value, including the maximum, can therefore be run to expiry and timed to the exact clock. Short intervals also make it cheap to measure freezes, refreshes and select changes against computed arrival edges, and to repeat randomized select and speed combinations many times.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  // Write target decoded from wr_sel
  typedef enum logic {
    REG_PROG = 1'b0,
    REG_SVC  = 1'b1
  } wdt_reg_e;

  localparam logic [7:0] KEY_OPEN  = 8'h1E;
  localparam logic [7:0] KEY_CLOSE = 8'hE1;

endpackage

// File: rtl/wdt_key_seq.sv
// Two-write unlock detector for the service register (R2, R3)
module wdt_key_seq
  import wdt_keyed_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY_A = DW'(KEY_OPEN),
  parameter logic [DW-1:0] KEY_B = DW'(KEY_CLOSE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          kick
);

  logic armed_q, armed_d;
  logic svc_wr, hit_a, hit_b;

  always_comb begin
    svc_wr  = wr_en && (wr_sel == 1'(REG_SVC));
    hit_a   = svc_wr && (wr_data == KEY_A);
    hit_b   = svc_wr && (wr_data == KEY_B);
    armed_d = armed_q;
    // Any write decides the armed state afresh: only the opening key arms
    if (wr_en) armed_d = hit_a;
    kick    = hit_b && armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

endmodule

// File: rtl/wdt_mc_prescaler.sv
// Divides enabled clocks into machine-cycle ticks (R6, R7)
module wdt_mc_prescaler #(
  parameter int SLOW_CLKS = 12,
  parameter int FAST_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  input  logic step,
  input  logic fast,
  output logic tick
);

  localparam int PW = (SLOW_CLKS > 2) ? $clog2(SLOW_CLKS) : 1;
  localparam logic [PW-1:0] SLOW_M1 = PW'(SLOW_CLKS - 1);
  localparam logic [PW-1:0] FAST_M1 = PW'(FAST_CLKS - 1);

  logic [PW-1:0] div_q, div_d, div_m1;

  always_comb begin
    div_m1 = fast ? FAST_M1 : SLOW_M1;
    tick   = run && !kick && step && (div_q >= div_m1);
    div_d  = div_q;
    if (kick || !run)  div_d = '0;
    else if (tick)     div_d = '0;
    else if (step)     div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/wdt_interval_counter.sv
// Machine-cycle counter with selectable interval (R2, R4, R9)
module wdt_interval_counter #(
  parameter int PRE_W = 14,
  parameter int SEL_W = 3,
  localparam int CNT_W = PRE_W + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last_val;

  always_comb begin
    // interval = 2^(PRE_W+sel) - 1 ticks; expiry on the tick seen at interval-1
    span     = {{CNT_W{1'b0}}, 1'b1} << (PRE_W + int'(sel));
    last_val = CNT_W'(span - (CNT_W + 1)'(2));
    expire   = run_q && tick && !kick && (cnt_q >= last_val);
    run_d    = run_q;
    cnt_d    = cnt_q;
    if (kick) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (expire) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (run_q && tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run = run_q;
  assign cnt = cnt_q;

endmodule

// File: rtl/wdt_rst_stretch.sv
// Fixed-length reset request pulse (R8)
module wdt_rst_stretch #(
  parameter int PULSE_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic pulse
);

  localparam int PCW = $clog2(PULSE_CLKS + 1);

  logic [PCW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (expire)             left_d = PCW'(PULSE_CLKS);
    else if (left_q != '0)  left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_keyed_pkg::*;
#(
  parameter int PRE_W      = 14,
  parameter int SEL_W      = 3,
  parameter int SLOW_CLKS  = 12,
  parameter int FAST_CLKS  = 6,
  parameter int PULSE_CLKS = 16,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          pwr_down,
  input  logic          fast_mode,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          wdt_rst
);

  localparam int CNT_W = PRE_W + (1 << SEL_W) - 1;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  // Program register (R5)
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en && (wr_sel == 1'(REG_PROG))) sel_d = wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  logic             kick, tick, run, expire, step;
  logic [CNT_W-1:0] cnt;

  // Counting is paused by a halted oscillator or a low enable (R7)
  assign step = clk_en && !pwr_down;

  wdt_key_seq #(
    .DW(DW)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_ns),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .kick   (kick)
  );

  wdt_mc_prescaler #(
    .SLOW_CLKS(SLOW_CLKS),
    .FAST_CLKS(FAST_CLKS)
  ) u_presc (
    .clk  (clk),
    .rst_n(rst_ns),
    .run  (run),
    .kick (kick),
    .step (step),
    .fast (fast_mode),
    .tick (tick)
  );

  wdt_interval_counter #(
    .PRE_W(PRE_W),
    .SEL_W(SEL_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_ns),
    .kick  (kick),
    .tick  (tick),
    .sel   (sel_q),
    .run   (run),
    .cnt   (cnt),
    .expire(expire)
  );

  wdt_rst_stretch #(
    .PULSE_CLKS(PULSE_CLKS)
  ) u_pulse (
    .clk   (clk),
    .rst_n (rst_ns),
    .expire(expire),
    .pulse (wdt_rst)
  );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W      = 21,
  parameter int PULSE_CLKS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             kick,
  input logic             expire,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             wdt_rst
);

  // Length of the current run of high request cycles
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (wdt_rst) hi_len <= (hi_len == 16'hFFFF) ? hi_len : hi_len + 16'd1;
    else              hi_len <= '0;
  end

  // R7: nothing advances while paused
  a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !kick) |=> $stable(cnt));

  // R4: a key pair restarts from zero
  a_r4_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (run && (cnt == '0)));

  // R8: expiry is followed by the request
  a_r8_expire_raises: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wdt_rst);

  // R8: the request only rises on an expiry
  a_r8_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(expire));

  // R8: pulse length
  a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (hi_len == 16'(PULSE_CLKS)));

endmodule

bind wdt_keyed_top wdt_keyed_chk #(
  .CNT_W     (CNT_W),
  .PULSE_CLKS(PULSE_CLKS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .step   (step),
  .kick   (kick),
  .expire (expire),
  .run    (run),
  .cnt    (cnt),
  .wdt_rst(wdt_rst)
);

// File: tb/wdt_keyed_top_tb_top.sv
module wdt_keyed_top_tb_top;

  localparam int TB_PRE   = 2;
  localparam int TB_SEL_W = 3;
  localparam int TB_SLOW  = 4;
  localparam int TB_FAST  = 2;
  localparam int TB_PULSE = 5;

  logic       clk;
  logic       rst_n;
  logic       clk_en;
  logic       pwr_down;
  logic       fast_mode;
  logic       wr_en;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       wdt_rst;

  int vec_cnt;
  int err_cnt;
  bit done;

  wdt_keyed_top #(
    .PRE_W     (TB_PRE),
    .SEL_W     (TB_SEL_W),
    .SLOW_CLKS (TB_SLOW),
    .FAST_CLKS (TB_FAST),
    .PULSE_CLKS(TB_PULSE),
    .DW        (8)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .pwr_down (pwr_down),
    .fast_mode(fast_mode),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .wdt_rst  (wdt_rst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_cyc(input int sel, input bit fast);
    return ((1 << (TB_PRE + sel)) - 1) * (fast ? TB_FAST : TB_SLOW);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic key_pair();
    wr(1'b1, 8'h1E);
    wr(1'b1, 8'hE1);
  endtask

  // Edges until wdt_rst is seen high (capped)
  task automatic meas(input int maxn, output int n);
    n = 0;
    do begin
      @(posedge clk); #5;
      n++;
    end while (!wdt_rst && n < maxn);
  endtask

  // Call right after a rise: count high cycles including the first
  task automatic pulse_w(output int w);
    w = 1;
    forever begin
      @(posedge clk); #5;
      if (wdt_rst) w++;
      else break;
    end
  endtask

  task automatic quiet(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      if (wdt_rst) highs++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    int n, w, h, sel, tot;
    bit fst;
    void'($urandom(32'd20240611));
    vec_cnt = 0; err_cnt = 0; done = 1'b0;
    rst_n = 1'b0; clk_en = 1'b1; pwr_down = 1'b0; fast_mode = 1'b0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset
    check(wdt_rst == 1'b0, "R1 reset value", int'(wdt_rst), 0);
    quiet(500, h);
    check(h == 0, "R1 idle without key", h, 0);

    // R5: reset select 0, R2 timing
    key_pair();
    meas(5000, n);
    check(n == exp_cyc(0, 0), "R5 R2 default select", n, exp_cyc(0, 0));
    pulse_w(w);
    check(w == TB_PULSE, "R8 pulse width", w, TB_PULSE);
    quiet(300, h);
    check(h == 0, "R8 idle after expiry", h, 0);

    // R5: upper data bits ignored (0xF9 -> select 1)
    wr(1'b0, 8'hF9);
    key_pair();
    meas(5000, n);
    check(n == exp_cyc(1, 0), "R5 upper bits ignored", n, exp_cyc(1, 0));
    pulse_w(w);

    // R2: longest interval
    wr(1'b0, 8'h07);
    key_pair();
    meas(5000, n);
    check(n == exp_cyc(7, 0), "R2 select 7", n, exp_cyc(7, 0));
    pulse_w(w);
    check(w == TB_PULSE, "R8 pulse width long", w, TB_PULSE);

    // R6: fast machine cycle
    wr(1'b0, 8'h01);
    @(negedge clk); fast_mode = 1'b1;
    key_pair();
    meas(5000, n);
    check(n == exp_cyc(1, 1), "R6 fast mode", n, exp_cyc(1, 1));
    pulse_w(w);
    @(negedge clk); fast_mode = 1'b0;

    // R3: broken sequences
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hE1);
    quiet(200, h);
    check(h == 0, "R3 lone E1", h, 0);
    wr(1'b1, 8'h1E); wr(1'b0, 8'h00); wr(1'b1, 8'hE1);
    quiet(200, h);
    check(h == 0, "R3 program write between keys", h, 0);
    wr(1'b1, 8'h1E); wr(1'b1, 8'h55); wr(1'b1, 8'hE1);
    quiet(200, h);
    check(h == 0, "R3 wrong second byte", h, 0);
    wr(1'b1, 8'h1E); wr(1'b1, 8'h1E); wr(1'b1, 8'hE1);
    meas(5000, n);
    check(n == exp_cyc(0, 0), "R3 repeated 1E re-arms", n, exp_cyc(0, 0));
    pulse_w(w);

    // R4: refresh restarts interval
    wr(1'b0, 8'h02);
    key_pair();
    repeat (40) @(posedge clk);
    #5;
    check(wdt_rst == 1'b0, "R4 no expiry before refresh", int'(wdt_rst), 0);
    key_pair();
    meas(5000, n);
    check(n == exp_cyc(2, 0), "R4 refresh timing", n, exp_cyc(2, 0));
    pulse_w(w);

    // R7: power-down freeze of 37 clocks
    wr(1'b0, 8'h01);
    key_pair();
    repeat (10) @(posedge clk);
    @(negedge clk); pwr_down = 1'b1;
    repeat (37) @(negedge clk);
    pwr_down = 1'b0;
    meas(5000, n);
    tot = 47 + n;
    check(tot == exp_cyc(1, 0) + 37, "R7 power-down freeze", tot, exp_cyc(1, 0) + 37);
    pulse_w(w);

    // R7: clock-enable low for 23 clocks
    key_pair();
    repeat (10) @(posedge clk);
    @(negedge clk); clk_en = 1'b0;
    repeat (23) @(negedge clk);
    clk_en = 1'b1;
    meas(5000, n);
    tot = 33 + n;
    check(tot == exp_cyc(1, 0) + 23, "R7 clock enable freeze", tot, exp_cyc(1, 0) + 23);
    pulse_w(w);

    // R9: lowering the select past the count expires on next tick
    wr(1'b0, 8'h03);
    key_pair();
    repeat (60) @(posedge clk);
    wr(1'b0, 8'h00);
    meas(5000, n);
    check(n == 3, "R9 select lowered", n, 3);
    pulse_w(w);

    // Random select / speed mix (R2, R6)
    for (int it = 0; it < 12; it++) begin
      sel = int'($urandom % 4);
      fst = 1'($urandom % 2);
      wr(1'b0, {5'($urandom), 3'(sel)});
      @(negedge clk); fast_mode = fst;
      key_pair();
      meas(5000, n);
      check(n == exp_cyc(sel, fst), "R2 R6 random interval", n, exp_cyc(sel, fst));
      pulse_w(w);
      check(w == TB_PULSE, "R8 random pulse width", w, TB_PULSE);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule